// File: doc/BRIEF.md
# Configuration Scrub Sequencer with Failure Probe

This controller keeps the configuration of a programmable device refreshed through a byte-wide configuration port. Bitstream transfer and the port protocol sit outside the block. Toward the port, the sequencer only names a segment and waits for an acknowledge.

After reset it issues a complete load of three segments:
- the fabric segment, which holds the clock, logic and I/O resources;
- user memory contents;
- memory control.

From then on it runs periodic scrub passes. A scrub pass rewrites only the fabric and memory-control segments, so user memory contents survive.

Each scrub pass also proves that it worked. Before the rewrite, the sequencer shifts a nonzero 16-bit signature into a one-bit-wide, 16-deep shift-register probe. A good fabric reload returns that probe to zero. After the rewrite, the sequencer shifts the probe out and flags a failure if any bit is still one. The signature alternates between two complementary-looking values on successive writes, so a probe stuck at the previous value is also caught.

A segment request that is not acknowledged in time abandons the pass and raises a sticky error. Pass and failure counters and a one-cycle completion pulse report progress. The block runs on the configuration clock, which keeps running after the first load.

Top module: `cfg_scrub_seq`

## Requirements
- R1: While reset is asserted, seg_req, probe_we, probe_re, init_done, pass_done, scrub_fail, timeout_err, pass_cnt and fail_cnt are all zero.
- R2: After reset, the power-up load requests segment codes 0 (fabric), 1 (memory contents) and 2 (memory control), in that order, one request each. init_done then goes high, and no probe activity happens before it does.
- R3: A scrub pass requests segment 0 and then segment 2, and never requests segment 1.
- R4: Before each scrub's segment requests, probe_we is high for exactly 16 cycles. It shifts the signature out on probe_din, most significant bit first. The first write after reset carries 0xA5C3, and successive writes alternate between 0x5A3C and 0xA5C3.
- R5: After the segment loads, probe_re is high for 16 cycles while probe_dout is sampled. scrub_fail shows whether any sampled bit was one, and each such pass adds one to fail_cnt.
- R6: Every completed scrub pass raises pass_done for exactly one cycle and adds one to pass_cnt.
- R7: seg_req, once raised, stays high with seg_id unchanged until seg_ack is seen or the timeout fires. It falls in the cycle after the acknowledge.
- R8: Count cycles of a request from 0, starting at the first cycle seg_req is high. An acknowledge in cycle k is accepted when k is at most ack_timeout-1 (a value of 0 acts as 1). Otherwise the pass is abandoned: no pass_done, no count change, and timeout_err is set and stays set.
- R9: A high err_clr clears timeout_err, unless a timeout fires in the same cycle.
- R10: probe_we and probe_re are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scrub_interval | input | IW | Idle cycles between passes (0 acts as 1) |
| ack_timeout | input | TW | Cycles a segment request may wait for acknowledge |
| err_clr | input | 1 | Clears the sticky timeout error |
| seg_req | output | 1 | Segment load request |
| seg_id | output | 2 | Segment code: 0 fabric, 1 memory contents, 2 memory control |
| seg_ack | input | 1 | Port acknowledge of the requested segment |
| probe_we | output | 1 | Probe shift-in enable |
| probe_din | output | 1 | Signature bit shifted into the probe |
| probe_re | output | 1 | Probe shift-out enable |
| probe_dout | input | 1 | Probe bit read back |
| init_done | output | 1 | Power-up load completed |
| pass_done | output | 1 | One-cycle pulse at the end of each completed scrub |
| scrub_fail | output | 1 | Last completed scrub left the probe nonzero |
| timeout_err | output | 1 | Sticky segment acknowledge timeout |
| pass_cnt | output | CW | Completed scrub passes |
| fail_cnt | output | CW | Failed scrub passes |

## Verification
The bench models the probe as a 16-bit shift register. A fabric acknowledge clears it unless a broken-scrub flag is chosen at random, so a design that misreads the probe, or reads it before the fabric reload, would show the wrong failure state.

The bench places acknowledges at the last accepted cycle and one cycle later. An off-by-one in the timeout counter would abandon a good pass or accept a late one.

Across many random passes, the bench checks:
- the segment order;
- that segment 1 never appears during scrubs;
- the alternation of the planted signature, including across an abandoned pass.

A sequencer that reloaded user memory, reused one signature, or mishandled its toggle after an abort would fail these checks.

It also verifies that the timeout error is sticky, and that the clear input removes it.

// File: rtl/scrub_pkg.sv
// Shared constants for the configuration scrub sequencer.
// Assumes a 16-deep one-bit probe and three segment codes.
package scrub_pkg;
    localparam int unsigned PROBE_LEN = 16;
    localparam logic [PROBE_LEN-1:0] SIG_FIRST  = 16'hA5C3;
    localparam logic [PROBE_LEN-1:0] SIG_SECOND = 16'h5A3C;

    localparam logic [1:0] SEG_FABRIC  = 2'd0;
    localparam logic [1:0] SEG_MEMDATA = 2'd1;
    localparam logic [1:0] SEG_MEMCTL  = 2'd2;

    typedef enum logic [2:0] {
        ST_BOOT,
        ST_IDLE,
        ST_WR_SIG,
        ST_SCRUB,
        ST_RD_PROBE,
        ST_REPORT
    } scrub_state_e;
endpackage

// File: rtl/scrub_seg_port.sv
// Segment request/acknowledge handshake with a bounded wait.
// A start pulse raises the request. Exactly one of ok/tmo pulses when it ends.
// Assumes start is never pulsed while a request is outstanding.
module scrub_seg_port #(
    parameter int unsigned TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    sel,
    input  logic [TW-1:0] limit,
    output logic          seg_req,
    output logic [1:0]    seg_id,
    input  logic          seg_ack,
    output logic          ok,
    output logic          tmo
);
    logic [TW-1:0] wait_cnt;
    logic [TW-1:0] last_idx;

    // Last cycle index at which an acknowledge is still accepted.
    always_comb last_idx = (limit == '0) ? '0 : limit - 1'b1;

    // Request, wait counter and completion pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_req  <= 1'b0;
            seg_id   <= 2'd0;
            wait_cnt <= '0;
            ok       <= 1'b0;
            tmo      <= 1'b0;
        end else begin
            ok  <= 1'b0;
            tmo <= 1'b0;
            if (start) begin
                seg_req  <= 1'b1;
                seg_id   <= sel;
                wait_cnt <= '0;
            end else if (seg_req) begin
                if (seg_ack) begin
                    seg_req <= 1'b0;
                    ok      <= 1'b1;
                end else if (wait_cnt == last_idx) begin
                    seg_req <= 1'b0;
                    tmo     <= 1'b1;
                end else begin
                    wait_cnt <= wait_cnt + 1'b1;
                end
            end
        end
    end

    p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_req && !seg_ack && !(wait_cnt == last_idx)) |=> (seg_req && $stable(seg_id)));
    p_req_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_req && seg_ack) |=> (!seg_req && ok));
    p_one_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(ok && tmo));
endmodule

// File: rtl/scrub_probe_io.sv
// Shifts a signature into the probe, or shifts the probe out and ORs its bits.
// Each operation takes LEN cycles and ends with a one-cycle done pulse.
// Assumes the starts are pulses and never overlap a running operation.
module scrub_probe_io #(
    parameter int unsigned LEN = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_start,
    input  logic           rd_start,
    input  logic [LEN-1:0] sig,
    output logic           probe_we,
    output logic           probe_din,
    output logic           probe_re,
    input  logic           probe_dout,
    output logic           wr_done,
    output logic           rd_done,
    output logic           rd_dirty
);
    localparam int unsigned CNTW = $clog2(LEN);
    localparam logic [CNTW-1:0] LAST = CNTW'(LEN - 1);

    logic [LEN-1:0]  shreg;
    logic [CNTW-1:0] bit_cnt;
    logic            wr_act;
    logic            rd_act;

    // Shift engine for both directions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg    <= '0;
            bit_cnt  <= '0;
            wr_act   <= 1'b0;
            rd_act   <= 1'b0;
            wr_done  <= 1'b0;
            rd_done  <= 1'b0;
            rd_dirty <= 1'b0;
        end else begin
            wr_done <= 1'b0;
            rd_done <= 1'b0;
            if (wr_start) begin
                shreg   <= sig;
                bit_cnt <= '0;
                wr_act  <= 1'b1;
            end else if (rd_start) begin
                bit_cnt  <= '0;
                rd_dirty <= 1'b0;
                rd_act   <= 1'b1;
            end else if (wr_act) begin
                shreg   <= {shreg[LEN-2:0], 1'b0};
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == LAST) begin
                    wr_act  <= 1'b0;
                    wr_done <= 1'b1;
                end
            end else if (rd_act) begin
                rd_dirty <= rd_dirty | probe_dout;
                bit_cnt  <= bit_cnt + 1'b1;
                if (bit_cnt == LAST) begin
                    rd_act  <= 1'b0;
                    rd_done <= 1'b1;
                end
            end
        end
    end

    // Probe pins follow the engine state.
    always_comb begin
        probe_we  = wr_act;
        probe_din = shreg[LEN-1];
        probe_re  = rd_act;
    end

    p_probe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(probe_we && probe_re));
    p_sig_msb_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_start |=> (probe_we && probe_din == $past(sig[LEN-1])));
endmodule

// File: rtl/scrub_interval_timer.sv
// Counts an idle interval and pulses expired once.
// A length of zero behaves as one cycle.
module scrub_interval_timer #(
    parameter int unsigned IW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [IW-1:0] len,
    output logic          expired
);
    logic [IW-1:0] remain;
    logic          running;

    // Down-counter with a one-cycle expiry pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain  <= '0;
            running <= 1'b0;
            expired <= 1'b0;
        end else begin
            expired <= 1'b0;
            if (start) begin
                remain  <= len;
                running <= 1'b1;
            end else if (running) begin
                if (remain <= 1) begin
                    running <= 1'b0;
                    expired <= 1'b1;
                end else begin
                    remain <= remain - 1'b1;
                end
            end
        end
    end

    p_expire_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
        expired |=> !expired);
endmodule

// File: rtl/cfg_scrub_seq.sv
// Top-level scrub sequencer. It performs the power-up full load, then repeats:
// idle interval, signature write, fabric and memory-control reloads,
// probe read, report.
// Assumes the port acknowledges each request at most once.
module cfg_scrub_seq #(
    parameter int unsigned IW = 16,
    parameter int unsigned TW = 8,
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] scrub_interval,
    input  logic [TW-1:0] ack_timeout,
    input  logic          err_clr,
    output logic          seg_req,
    output logic [1:0]    seg_id,
    input  logic          seg_ack,
    output logic          probe_we,
    output logic          probe_din,
    output logic          probe_re,
    input  logic          probe_dout,
    output logic          init_done,
    output logic          pass_done,
    output logic          scrub_fail,
    output logic          timeout_err,
    output logic [CW-1:0] pass_cnt,
    output logic [CW-1:0] fail_cnt
);
    import scrub_pkg::*;

    localparam logic [1:0] BOOT_LAST  = 2'd2;
    localparam logic [1:0] SCRUB_LAST = 2'd1;

    scrub_state_e state;
    logic [1:0]   step;
    logic         launched;
    logic         sig_phase;
    logic [1:0]   seg_sel;
    logic         seg_start, seg_ok, seg_tmo;
    logic         wr_start, rd_start, wr_done, rd_done, rd_dirty;
    logic         tmr_start, tmr_exp;
    logic [PROBE_LEN-1:0] sig_word;

    // Segment selection for the current load step.
    always_comb begin
        if (state == ST_BOOT) begin
            case (step)
                2'd0:    seg_sel = SEG_FABRIC;
                2'd1:    seg_sel = SEG_MEMDATA;
                default: seg_sel = SEG_MEMCTL;
            endcase
        end else begin
            seg_sel = (step == 2'd0) ? SEG_FABRIC : SEG_MEMCTL;
        end
    end

    // One launch per state entry for each helper.
    always_comb begin
        seg_start = !launched && (state == ST_BOOT || state == ST_SCRUB);
        wr_start  = !launched && (state == ST_WR_SIG);
        rd_start  = !launched && (state == ST_RD_PROBE);
        tmr_start = !launched && (state == ST_IDLE);
        sig_word  = sig_phase ? SIG_SECOND : SIG_FIRST;
    end

    // Main sequence, status flags and counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_BOOT;
            step        <= 2'd0;
            launched    <= 1'b0;
            sig_phase   <= 1'b0;
            init_done   <= 1'b0;
            pass_done   <= 1'b0;
            scrub_fail  <= 1'b0;
            timeout_err <= 1'b0;
            pass_cnt    <= '0;
            fail_cnt    <= '0;
        end else begin
            pass_done <= 1'b0;
            if (seg_start || wr_start || rd_start || tmr_start) begin
                launched <= 1'b1;
            end
            if (err_clr) begin
                timeout_err <= 1'b0;
            end
            case (state)
                ST_BOOT: begin
                    if (seg_ok) begin
                        launched <= 1'b0;
                        if (step == BOOT_LAST) begin
                            init_done <= 1'b1;
                            state     <= ST_IDLE;
                        end else begin
                            step <= step + 1'b1;
                        end
                    end else if (seg_tmo) begin
                        timeout_err <= 1'b1;
                        launched    <= 1'b0;
                        state       <= ST_IDLE;
                    end
                end
                ST_IDLE: begin
                    if (tmr_exp) begin
                        launched <= 1'b0;
                        step     <= 2'd0;
                        state    <= init_done ? ST_WR_SIG : ST_BOOT;
                    end
                end
                ST_WR_SIG: begin
                    if (wr_done) begin
                        sig_phase <= !sig_phase;
                        launched  <= 1'b0;
                        step      <= 2'd0;
                        state     <= ST_SCRUB;
                    end
                end
                ST_SCRUB: begin
                    if (seg_ok) begin
                        launched <= 1'b0;
                        if (step == SCRUB_LAST) begin
                            state <= ST_RD_PROBE;
                        end else begin
                            step <= step + 1'b1;
                        end
                    end else if (seg_tmo) begin
                        timeout_err <= 1'b1;
                        launched    <= 1'b0;
                        state       <= ST_IDLE;
                    end
                end
                ST_RD_PROBE: begin
                    if (rd_done) begin
                        scrub_fail <= rd_dirty;
                        if (rd_dirty) begin
                            fail_cnt <= fail_cnt + 1'b1;
                        end
                        launched <= 1'b0;
                        state    <= ST_REPORT;
                    end
                end
                ST_REPORT: begin
                    pass_done <= 1'b1;
                    pass_cnt  <= pass_cnt + 1'b1;
                    launched  <= 1'b0;
                    state     <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    scrub_seg_port #(.TW(TW)) u_port (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (seg_start),
        .sel     (seg_sel),
        .limit   (ack_timeout),
        .seg_req (seg_req),
        .seg_id  (seg_id),
        .seg_ack (seg_ack),
        .ok      (seg_ok),
        .tmo     (seg_tmo)
    );

    scrub_probe_io #(.LEN(PROBE_LEN)) u_probe (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_start   (wr_start),
        .rd_start   (rd_start),
        .sig        (sig_word),
        .probe_we   (probe_we),
        .probe_din  (probe_din),
        .probe_re   (probe_re),
        .probe_dout (probe_dout),
        .wr_done    (wr_done),
        .rd_done    (rd_done),
        .rd_dirty   (rd_dirty)
    );

    scrub_interval_timer #(.IW(IW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (tmr_start),
        .len     (scrub_interval),
        .expired (tmr_exp)
    );

    p_no_memdata_scrub_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_req && init_done) |-> (seg_id != SEG_MEMDATA));
    p_no_probe_boot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !init_done |-> (!probe_we && !probe_re));
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pass_done |=> !pass_done);
    p_pass_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pass_done |-> (pass_cnt == $past(pass_cnt) + 1'b1));
    p_tmo_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_err && !err_clr) |=> timeout_err);
    p_tmo_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
        seg_tmo |=> timeout_err);
    p_err_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr && !seg_tmo) |=> !timeout_err);
endmodule

// File: tb/tb_cfg_scrub_seq.sv
module tb_cfg_scrub_seq;
    localparam int CLK_PERIOD = 10;
    localparam int IW = 8;
    localparam int TW = 8;
    localparam int CW = 16;
    localparam int TMO = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [IW-1:0] scrub_interval;
    logic [TW-1:0] ack_timeout;
    logic          err_clr;
    logic          seg_req;
    logic [1:0]    seg_id;
    logic          seg_ack;
    logic          probe_we, probe_din, probe_re, probe_dout;
    logic          init_done, pass_done, scrub_fail, timeout_err;
    logic [CW-1:0] pass_cnt, fail_cnt;

    cfg_scrub_seq #(.IW(IW), .TW(TW), .CW(CW)) dut (
        .clk(clk), .rst_n(rst_n), .scrub_interval(scrub_interval),
        .ack_timeout(ack_timeout), .err_clr(err_clr),
        .seg_req(seg_req), .seg_id(seg_id), .seg_ack(seg_ack),
        .probe_we(probe_we), .probe_din(probe_din), .probe_re(probe_re),
        .probe_dout(probe_dout), .init_done(init_done), .pass_done(pass_done),
        .scrub_fail(scrub_fail), .timeout_err(timeout_err),
        .pass_cnt(pass_cnt), .fail_cnt(fail_cnt)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;
    int ack_delay = 1;
    bit broken = 1'b0;
    logic [15:0] mdl = '0;
    logic [1:0] seq [0:63];
    int seq_n = 0;
    logic [15:0] sig_seen = '0;
    int bcnt = 0;
    int we_run = 0, we_last = 0, wr_runs = 0;
    int overlap_cnt = 0, early_probe = 0, r7_viol = 0, done_seen = 0;
    bit prev_req = 0, prev_ack = 0;
    logic [1:0] prev_id = 0;

    assign probe_dout = mdl[15];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_sig(input int nwrites);
        return (nwrites % 2 == 1) ? 16'hA5C3 : 16'h5A3C;
    endfunction

    // Probe model: shifts on write/read, cleared by a good fabric reload.
    always @(posedge clk) begin
        if (probe_we) mdl <= {mdl[14:0], probe_din};
        else if (probe_re) mdl <= {mdl[14:0], 1'b0};
        else if (seg_req && seg_ack && seg_id == 2'd0 && !broken) mdl <= '0;
    end

    // Port responder and monitors.
    always @(negedge clk) begin
        cycles++;
        if (!rst_n) begin
            seg_ack = 1'b0;
            bcnt = 0;
        end else begin
            if (prev_req && !prev_ack && seg_req && seg_id != prev_id) r7_viol++;
            if (prev_req && prev_ack && seg_req) r7_viol++;
            prev_req = seg_req; prev_id = seg_id; prev_ack = seg_ack;
            if (seg_req && !seg_ack) begin
                if (bcnt == ack_delay) begin
                    seg_ack = 1'b1;
                    if (seq_n < 64) seq[seq_n] = seg_id;
                    seq_n++;
                    if (seg_id == 2'd0) sig_seen = mdl;
                end else begin
                    bcnt++;
                end
            end else if (!seg_req) begin
                seg_ack = 1'b0;
                bcnt = 0;
            end
            if (probe_we) we_run++;
            else if (we_run != 0) begin
                we_last = we_run; wr_runs++; we_run = 0;
            end
            if (probe_we && probe_re) overlap_cnt++;
            if (!init_done && (probe_we || probe_re)) early_probe++;
            if (pass_done) done_seen++;
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        wait (cycles > 100000);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    task automatic wait_pass(output bit got);
        got = 0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (pass_done) begin got = 1; break; end
        end
    endtask

    initial begin
        bit got;
        int exp_pass = 0, exp_fail = 0, d;
        void'($urandom(32'h5C2B));
        scrub_interval = 8'd4;
        ack_timeout = TMO;
        err_clr = 1'b0;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(!seg_req && !probe_we && !probe_re, "R1 pins", {seg_req, probe_we, probe_re}, 0);
        chk(!init_done && !pass_done && !scrub_fail && !timeout_err, "R1 flags",
            {init_done, pass_done, scrub_fail, timeout_err}, 0);
        chk(pass_cnt == 0 && fail_cnt == 0, "R1 counts", pass_cnt + fail_cnt, 0);
        rst_n = 1'b1;
        for (int i = 0; i < 500 && !init_done; i++) @(negedge clk);
        // R2 power-up order
        chk(init_done, "R2 init_done", init_done, 1);
        chk(seq_n == 3, "R2 count", seq_n, 3);
        chk(seq[0] == 0 && seq[1] == 1 && seq[2] == 2, "R2 order",
            {seq[0], seq[1], seq[2]}, 6'b000110);
        chk(early_probe == 0, "R2 probe quiet", early_probe, 0);

        for (int p = 0; p < 14; p++) begin
            if (p == 2) d = TMO - 1;          // R8 boundary: last accepted cycle
            else if (p == 3) d = 0;
            else d = $urandom % TMO;
            ack_delay = d;
            broken = (p == 1) || ($urandom % 3 == 0);
            scrub_interval = (p == 4) ? 8'd0 : IW'($urandom % 6);
            seq_n = 0;
            wait_pass(got);
            chk(got, "R6 pass completes", got, 1);
            if (!got) break;
            exp_pass++;
            if (broken) exp_fail++;
            chk(seq_n == 2 && seq[0] == 0 && seq[1] == 2, "R3 scrub segments",
                {seq[0], seq[1]}, 4'b0010);
            chk(sig_seen == exp_sig(wr_runs), "R4 signature", sig_seen, exp_sig(wr_runs));
            chk(we_last == 16, "R4 write length", we_last, 16);
            chk(scrub_fail == broken, "R5 scrub_fail", scrub_fail, broken);
            chk(fail_cnt == exp_fail, "R5 fail_cnt", fail_cnt, exp_fail);
            chk(pass_cnt == exp_pass, "R6 pass_cnt", pass_cnt, exp_pass);
            @(negedge clk);
            chk(!pass_done, "R6 single pulse", pass_done, 0);
        end

        // R8: an acknowledge one cycle too late abandons the pass.
        ack_delay = TMO;
        broken = 1'b0;
        done_seen = 0;
        for (int i = 0; i < 3000 && !timeout_err; i++) @(negedge clk);
        ack_delay = 1;
        chk(timeout_err, "R8 timeout flag", timeout_err, 1);
        chk(done_seen == 0, "R8 no done", done_seen, 0);
        chk(pass_cnt == exp_pass, "R8 count held", pass_cnt, exp_pass);
        repeat (10) @(negedge clk);
        chk(timeout_err, "R8 sticky", timeout_err, 1);
        // R9 clear
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        @(negedge clk);
        chk(!timeout_err, "R9 cleared", timeout_err, 0);
        // Pass after abort: signature keeps alternating per write.
        seq_n = 0;
        wait_pass(got);
        exp_pass++;
        chk(got && sig_seen == exp_sig(wr_runs), "R4 signature after abort", sig_seen, exp_sig(wr_runs));
        chk(pass_cnt == exp_pass, "R6 pass_cnt after abort", pass_cnt, exp_pass);
        chk(overlap_cnt == 0, "R10 probe exclusive", overlap_cnt, 0);
        chk(r7_viol == 0, "R7 handshake", r7_viol, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule